// File: doc/BRIEF.md
# Serially Loaded Bank Window Mapper

This block translates addresses for a small processor that sees a 32 KiB window into a much larger 24-bit main bus. Any access the processor makes inside the window is sent on to the main bus. The main-bus address is a bank base plus the 15-bit offset within the window. Reads come back from the main bus unchanged, and writes go through in the same cycle.

The bank base is not written in one go. It is loaded through a one-byte register location, one address bit per write. On each write, bit 0 of the written byte enters at base bit 23. The bits already held move one place toward bit 15, and the bit that was at bit 15 is dropped. Base bits 14 to 0 are always zero, so the 9-bit bank is fully replaced after nine writes. Software loads a bank by writing bit 15 of the target base first and bit 23 last.

Because the low base bits are zero, the main-bus address is the 9-bit bank joined to the window offset, and no adder is needed. Main-bus wait states and arbitration sit outside this block.

Top module: `bank_window_mapper`

## Requirements
- R1: After reset the bank is zero, so an access at window offset X drives main-bus address X.
- R2: The main-bus address has the window offset in bits 14 to 0 and the 9 held bank bits in bits 23 to 15.
- R3: A bank write puts bit 0 of the written byte into address bit 23 and moves each held bank bit down one place toward bit 15. The bit that was at bit 15 is dropped. The new bank applies from the cycle after the write.
- R4: Bits 7 to 1 of the bank write data have no effect on the bank.
- R5: Nine bank writes replace the whole bank. The first written bit ends at address bit 15 and the ninth at bit 23.
- R6: The bank is unchanged in every cycle without a bank write, whatever window accesses take place.
- R7: Window reads drive the main-bus read strobe in the same cycle, and the main-bus read data appears unchanged on the window read data in that cycle.
- R8: Window writes drive the main-bus write strobe and write data in the same cycle, with the data unchanged.
- R9: A window access in the same cycle as a bank write uses the bank from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| win_addr | input | 15 | Offset of the access within the window |
| win_rd | input | 1 | Window read strobe |
| win_wr | input | 1 | Window write strobe |
| win_wdata | input | 8 | Window write data |
| win_rdata | output | 8 | Window read data |
| bank_we | input | 1 | Bank register write strobe |
| bank_wdata | input | 8 | Bank register write data; only bit 0 is used |
| mb_addr | output | 24 | Main-bus address |
| mb_rd | output | 1 | Main-bus read strobe |
| mb_wr | output | 1 | Main-bus write strobe |
| mb_wdata | output | 8 | Main-bus write data |
| mb_rdata | input | 8 | Main-bus read data |

## Verification
The window path is combinational, so the main-bus address, the strobes and both data directions are due in the same cycle as the stimulus. The bench drives them on the falling edge and samples one nanosecond later. A bank write takes effect at the next rising edge. The bench samples the old address before that edge and the new one just after it, which also covers a bank write and a window access in the same cycle. After reset the bench waits for the two-stage reset release before it checks anything. The model bank in the bench is updated only on the edge where the write is captured.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
  localparam int unsigned BWM_MB_AW  = 24;
  localparam int unsigned BWM_WIN_AW = 15;
  localparam int unsigned BWM_DW     = 8;
endpackage

// File: rtl/bwm_rst_sync.sv
module bwm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/bwm_bank_shift.sv
module bwm_bank_shift #(
  parameter int unsigned BANK_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              load_bit,
  output logic [BANK_W-1:0] bank
);
  logic [BANK_W-1:0] bank_q;
  logic [BANK_W-1:0] bank_d;

  always_comb begin
    bank_d = bank_q;
    if (load_en) bank_d = {load_bit, bank_q[BANK_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else        bank_q <= bank_d;
  end

  assign bank = bank_q;

  // R3
  bank_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> bank_q == {$past(load_bit), $past(bank_q[BANK_W-1:1])});

  // R6
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(bank_q));
endmodule

// File: rtl/bwm_route.sv
module bwm_route #(
  parameter int unsigned MB_AW  = 24,
  parameter int unsigned WIN_AW = 15,
  parameter int unsigned DW     = 8,
  localparam int unsigned BANK_W = MB_AW - WIN_AW
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [WIN_AW-1:0] win_addr,
  input  logic              win_rd,
  input  logic              win_wr,
  input  logic [DW-1:0]     win_wdata,
  output logic [DW-1:0]     win_rdata,
  output logic [MB_AW-1:0]  mb_addr,
  output logic              mb_rd,
  output logic              mb_wr,
  output logic [DW-1:0]     mb_wdata,
  input  logic [DW-1:0]     mb_rdata
);
  always_comb begin
    mb_addr   = {bank, win_addr};
    mb_rd     = win_rd;
    mb_wr     = win_wr;
    mb_wdata  = win_wdata;
    win_rdata = mb_rdata;
  end
endmodule

// File: rtl/bank_window_mapper.sv
module bank_window_mapper
  import bwm_pkg::*;
#(
  parameter int unsigned MB_AW  = BWM_MB_AW,
  parameter int unsigned WIN_AW = BWM_WIN_AW,
  parameter int unsigned DW     = BWM_DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIN_AW-1:0] win_addr,
  input  logic              win_rd,
  input  logic              win_wr,
  input  logic [DW-1:0]     win_wdata,
  output logic [DW-1:0]     win_rdata,
  input  logic              bank_we,
  input  logic [DW-1:0]     bank_wdata,
  output logic [MB_AW-1:0]  mb_addr,
  output logic              mb_rd,
  output logic              mb_wr,
  output logic [DW-1:0]     mb_wdata,
  input  logic [DW-1:0]     mb_rdata
);
  localparam int unsigned BANK_W = MB_AW - WIN_AW;

  logic              rst_n_s;
  logic [BANK_W-1:0] bank;
  logic              unused_bank_hi;

  // R4: only bit 0 of the bank data is consumed
  assign unused_bank_hi = ^bank_wdata[DW-1:1];

  bwm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  bwm_bank_shift #(.BANK_W(BANK_W)) u_bank (
    .clk(clk), .rst_n(rst_n_s), .load_en(bank_we),
    .load_bit(bank_wdata[0]), .bank(bank)
  );

  bwm_route #(.MB_AW(MB_AW), .WIN_AW(WIN_AW), .DW(DW)) u_route (
    .bank(bank), .win_addr(win_addr), .win_rd(win_rd), .win_wr(win_wr),
    .win_wdata(win_wdata), .win_rdata(win_rdata), .mb_addr(mb_addr),
    .mb_rd(mb_rd), .mb_wr(mb_wr), .mb_wdata(mb_wdata), .mb_rdata(mb_rdata)
  );

  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (win_rd || win_wr) |-> mb_addr[WIN_AW-1:0] == win_addr);

  // R8
  wr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    win_wr |-> (mb_wr && mb_wdata == win_wdata));

  // R7
  rd_pass_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    win_rd |-> (mb_rd && win_rdata == mb_rdata));

  // R9
  bank_late_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bank_we && (win_rd || win_wr)) |=> $past(mb_addr[MB_AW-1:WIN_AW]) == {mb_addr[MB_AW-2:WIN_AW], $past(mb_addr[WIN_AW])});
endmodule

// File: tb/bank_window_mapper_bench.sv
`timescale 1ns/1ps
module bank_window_mapper_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [14:0] win_addr;
  logic        win_rd, win_wr;
  logic [7:0]  win_wdata, win_rdata;
  logic        bank_we;
  logic [7:0]  bank_wdata;
  logic [23:0] mb_addr;
  logic        mb_rd, mb_wr;
  logic [7:0]  mb_wdata, mb_rdata;

  int checks = 0;
  int fails  = 0;
  logic [8:0] m_bank;

  always #2 clk = ~clk;

  bank_window_mapper u_bank_window_mapper (
    .clk(clk), .rst_n(rst_n), .win_addr(win_addr), .win_rd(win_rd),
    .win_wr(win_wr), .win_wdata(win_wdata), .win_rdata(win_rdata),
    .bank_we(bank_we), .bank_wdata(bank_wdata), .mb_addr(mb_addr),
    .mb_rd(mb_rd), .mb_wr(mb_wr), .mb_wdata(mb_wdata), .mb_rdata(mb_rdata)
  );

  function automatic logic [23:0] exp_addr(logic [8:0] b, logic [14:0] off);
    return {b, off};
  endfunction

  function automatic logic [8:0] exp_shift(logic [8:0] b, logic [7:0] d);
    return {d[0], b[8:1]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    win_rd = 0; win_wr = 0; bank_we = 0;
  endtask

  task automatic bank_write(logic [7:0] d);
    @(negedge clk);
    idle();
    bank_we = 1; bank_wdata = d;
    @(posedge clk); #1;
    m_bank = exp_shift(m_bank, d);
    bank_we = 0;
  endtask

  task automatic probe(string req, logic [14:0] off);
    @(negedge clk);
    idle();
    win_addr = off; win_rd = 1;
    #1 chk(req, 32'(mb_addr), 32'(exp_addr(m_bank, off)));
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle();
    win_addr = 0; win_wdata = 0; bank_wdata = 0; mb_rdata = 0;
    m_bank = '0;
    rst_n = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);

    // R1: reset bank zero
    probe("R1", 15'h1234);
    probe("R1", 15'h7FFF);

    // R5: load bank 9'h1A5 with bit15 first, using noise in upper bits (R4)
    for (int i = 0; i < 9; i++) bank_write({7'h55, 1'(9'h1A5 >> i)});
    probe("R5", 15'h0000);
    chk("R5", 32'(mb_addr[23:15]), 32'h1A5);

    // R4: upper bits only vary, lsb set
    bank_write(8'hFE); probe("R4", 15'h0042);
    bank_write(8'h01); probe("R4", 15'h0042);

    // R3: single shift
    bank_write(8'h00); probe("R3", 15'h2A2A);

    // R6: many accesses without bank write
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      idle();
      win_addr = 15'($urandom); win_wr = 1'($urandom);
      win_rd = ~win_wr; mb_rdata = 8'($urandom);
    end
    probe("R6", 15'h0101);

    // R9: bank write coinciding with a window access
    @(negedge clk);
    idle();
    bank_we = 1; bank_wdata = 8'h01; win_rd = 1; win_addr = 15'h0777;
    #1 chk("R9 old bank", 32'(mb_addr), 32'(exp_addr(m_bank, 15'h0777)));
    @(posedge clk); #1;
    m_bank = exp_shift(m_bank, 8'h01);
    bank_we = 0;
    chk("R9 new bank", 32'(mb_addr), 32'(exp_addr(m_bank, 15'h0777)));

    // Random mix: R2 R3 R7 R8
    void'($urandom(32'd7));
    for (int i = 0; i < 400; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      if ($urandom_range(3) == 0) begin
        bank_write(d);
      end else begin
        @(negedge clk);
        idle();
        win_addr = 15'($urandom);
        win_wdata = 8'($urandom);
        mb_rdata = 8'($urandom);
        if (d[0]) win_wr = 1; else win_rd = 1;
        #1;
        chk("R2", 32'(mb_addr), 32'(exp_addr(m_bank, win_addr)));
        if (d[0]) begin
          chk("R8 strobe", 32'(mb_wr), 32'd1);
          chk("R8 data", 32'(mb_wdata), 32'(win_wdata));
        end else begin
          chk("R7 strobe", 32'(mb_rd), 32'd1);
          chk("R7 data", 32'(win_rdata), 32'(mb_rdata));
        end
      end
    end

    @(negedge clk);
    idle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule